// File: doc/BRIEF.md
# Fractional Clock Rate Controller

This block turns every cycle of a parent clock into a qualified or unqualified cycle, so that downstream logic clocked by the parent and gated by the enable strobe runs at a programmable fraction of the parent rate. The fraction is set in steps of one thirty-second. A 5-bit reduction value `f` gives an effective rate of (32 − f)/32 of the parent. With `f` = 0 every cycle is enabled. With `f` = 31 one cycle in 32 is enabled.

Software uses a two-register port. Register 0 holds the reduction value in bits 12:8, and every other bit of that register is plain storage, so a read-modify-write keeps them. Register 1 holds a self-clearing apply request in bit 31. Software first writes the reduction value, which goes only into a staging copy. It then sets the apply bit and polls that bit until it reads 0.

The hardware counts a free-running frame of 32 parent cycles from reset. It copies the staged value into the active value at the last cycle of the frame that is in progress when the request is seen, and it clears the request in the same cycle. Each frame then carries exactly 32 − `f` enables, spread evenly by a wrapping accumulator.

Top module: `frac_rate_ctrl`

## Requirements
- R1: After reset, both registers read 0, no apply request is pending, and `clkEn` is 1 on every cycle.
- R2: A write to register 0 (`regSel`=0) stores all 32 bits. Reads of register 0 return the staged reduction value in bits 12:8 and the written value in all other bits.
- R3: A write to register 1 (`regSel`=1) with bit 31 set raises the apply request, and reads of register 1 show it in bit 31. Writing 0 to bit 31 does not clear a pending request. Bits 30:0 of register 1 always read 0.
- R4: A change to the staged reduction value has no effect on `clkEn` until an apply request has completed.
- R5: A frame position counts 0..31, starting at 0 on the first cycle after reset and advancing every cycle. A pending request is applied at the clock edge that ends position 31: the staged value becomes active and the request bit clears on that same edge. A request therefore never stays pending for more than 32 cycles.
- R6: With active reduction `f` and step `s` = 32 − `f`, `clkEn` is 1 at frame position `p` exactly when floor((p+1)·s/32) > floor(p·s/32). Each frame therefore carries exactly `s` enables.
- R7: While a request is pending, writes to register 0 leave the staged reduction value unchanged but still update the other bits.
- R8: A write that sets bit 31 of register 1 in the cycle that completes a pending request is treated as busy and discarded. The request bit reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | Register select for both read and write: 0 = fraction register, 1 = apply register |
| wrEn | input | 1 | Write strobe for the selected register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the selected register (combinational) |
| clkEn | output | 1 | Clock-enable strobe at the programmed fraction |

## Verification
The bench moves the request edge around the frame. It sets the request mid-frame, one cycle before the frame end, and again on the frame end itself. A design that applied the value immediately, or at the wrong boundary, would show a shifted enable pattern. A design that let the late request through would leave the bit stuck at 1. The bench also writes the staging field while a request is pending: a design that accepted that write would apply the wrong fraction, which shows up as a wrong enable count in the next frame. The extremes (full rate, 1/32 and 1/2) and odd steps such as 31 and 25 exercise accumulator wrap. A design whose wrap or carry was off by one would drop or add an enable within the frame.

// File: rtl/frac_rate_pkg.sv
package frac_rate_pkg;
  // Strobes from the control module to the datapath
  typedef struct packed {
    logic shadowWr;   // accept a new staged reduction value
    logic kickSet;    // apply request accepted this cycle
    logic applyNow;   // copy staged value into the active value
  } ctlStrb_t;
endpackage

// File: rtl/frac_rate_ctl.sv
module frac_rate_ctl
  import frac_rate_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     wrEn,
  input  logic     regSel,
  input  logic     wrKick,
  input  logic     frameEnd,
  output ctlStrb_t strb,
  output logic     kickQ
);

  always_comb begin
    strb.applyNow = kickQ & frameEnd;
    // a request arriving while one is pending is busy and dropped
    strb.kickSet  = wrEn & regSel & wrKick & ~kickQ;
    // the staged value is frozen while a request is pending
    strb.shadowWr = wrEn & ~regSel & ~kickQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kickQ <= 1'b0;
    end else if (strb.applyNow) begin
      kickQ <= 1'b0;
    end else if (strb.kickSet) begin
      kickQ <= 1'b1;
    end
  end

endmodule

// File: rtl/frac_rate_dp.sv
module frac_rate_dp
  import frac_rate_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FRAME_BITS = 5,
  parameter int FIELD_LSB  = 8,
  parameter int KICK_BIT   = 31
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrb_t              strb,
  input  logic                  wrEn,
  input  logic                  regSel,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  kickQ,
  output logic [DATA_W-1:0]     rdData,
  output logic                  clkEn,
  output logic                  frameEnd,
  output logic [FRAME_BITS-1:0] activeFrac,
  output logic [FRAME_BITS-1:0] shadowFrac
);

  localparam logic [FRAME_BITS:0] FULL_STEP = {1'b1, {FRAME_BITS{1'b0}}};

  logic [DATA_W-1:0]     fieldMask;
  logic [DATA_W-1:0]     otherQ;
  logic [DATA_W-1:0]     fieldWord;
  logic [DATA_W-1:0]     kickWord;
  logic [FRAME_BITS-1:0] frameCnt;
  logic [FRAME_BITS-1:0] accQ;
  logic [FRAME_BITS:0]   stepVal;
  logic [FRAME_BITS:0]   accSum;

  always_comb begin
    fieldMask = '0;
    fieldMask[FIELD_LSB +: FRAME_BITS] = '1;
  end

  // Register storage: staged field and the preserved remainder
  always_ff @(posedge clk) begin
    if (!rstN) begin
      otherQ     <= '0;
      shadowFrac <= '0;
    end else begin
      if (wrEn && !regSel) begin
        otherQ <= wrData & ~fieldMask;
      end
      if (strb.shadowWr) begin
        shadowFrac <= wrData[FIELD_LSB +: FRAME_BITS];
      end
    end
  end

  // Active fraction, loaded only on an apply strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeFrac <= '0;
    end else if (strb.applyNow) begin
      activeFrac <= shadowFrac;
    end
  end

  // Free-running frame position
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameCnt <= '0;
    end else begin
      frameCnt <= frameCnt + 1'b1;
    end
  end

  assign frameEnd = (frameCnt == {FRAME_BITS{1'b1}});

  // Pulse-swallowing accumulator: carry out marks an enabled cycle
  always_comb begin
    stepVal = FULL_STEP - {1'b0, activeFrac};
    accSum  = {1'b0, accQ} + stepVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ <= '0;
    end else if (frameEnd) begin
      accQ <= '0;
    end else begin
      accQ <= accSum[FRAME_BITS-1:0];
    end
  end

  assign clkEn = accSum[FRAME_BITS];

  // Read mux
  always_comb begin
    fieldWord = '0;
    fieldWord[FIELD_LSB +: FRAME_BITS] = shadowFrac;
    kickWord = '0;
    kickWord[KICK_BIT] = kickQ;
    rdData = regSel ? kickWord : (otherQ | fieldWord);
  end

endmodule

// File: rtl/frac_rate_ctrl.sv
module frac_rate_ctrl
  import frac_rate_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FRAME_BITS = 5,
  parameter int FIELD_LSB  = 8,
  parameter int KICK_BIT   = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              clkEn
);

  ctlStrb_t              strb;
  logic                  kickQ;
  logic                  frameEnd;
  logic [FRAME_BITS-1:0] activeFrac;
  logic [FRAME_BITS-1:0] shadowFrac;

  frac_rate_ctl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .regSel   (regSel),
    .wrKick   (wrData[KICK_BIT]),
    .frameEnd (frameEnd),
    .strb     (strb),
    .kickQ    (kickQ)
  );

  frac_rate_dp #(
    .DATA_W     (DATA_W),
    .FRAME_BITS (FRAME_BITS),
    .FIELD_LSB  (FIELD_LSB),
    .KICK_BIT   (KICK_BIT)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrEn       (wrEn),
    .regSel     (regSel),
    .wrData     (wrData),
    .kickQ      (kickQ),
    .rdData     (rdData),
    .clkEn      (clkEn),
    .frameEnd   (frameEnd),
    .activeFrac (activeFrac),
    .shadowFrac (shadowFrac)
  );

endmodule

// File: rtl/frac_rate_ctrl_chk.sv
module frac_rate_ctrl_chk #(
  parameter int DATA_W     = 32,
  parameter int FRAME_BITS = 5,
  parameter int KICK_BIT   = 31
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  regSel,
  input logic [DATA_W-1:0]     rdData,
  input logic                  clkEn,
  input logic                  kickQ,
  input logic                  frameEnd,
  input logic [FRAME_BITS-1:0] activeFrac,
  input logic [FRAME_BITS-1:0] shadowFrac
);

  localparam logic [FRAME_BITS:0] FULL_STEP = {1'b1, {FRAME_BITS{1'b0}}};

  logic [DATA_W-1:0]   kickMask;
  logic [FRAME_BITS:0] enCnt;
  logic [FRAME_BITS:0] kickAge;

  always_comb begin
    kickMask = '0;
    kickMask[KICK_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enCnt   <= '0;
      kickAge <= '0;
    end else begin
      enCnt   <= frameEnd ? '0 : enCnt + {{FRAME_BITS{1'b0}}, clkEn};
      kickAge <= kickQ ? kickAge + 1'b1 : '0;
    end
  end

  // R3: only the request bit of register 1 can read as 1
  p_kick_reg_bits_r3: assert property (@(posedge clk) disable iff (!rstN)
    regSel |-> ((rdData & ~kickMask) == '0));

  // R4: the active value moves only on a completed request
  p_active_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(kickQ && frameEnd) |-> $stable(activeFrac));

  // R5: the request clears only at a frame end
  p_kick_clear_frame_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(kickQ) |-> $past(frameEnd));

  // R5: the staged value is loaded on completion
  p_apply_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    (kickQ && frameEnd) |=> (!kickQ && activeFrac == $past(shadowFrac)));

  // R5: bounded completion latency
  p_kick_age_r5: assert property (@(posedge clk) disable iff (!rstN)
    kickQ |-> (kickAge < FULL_STEP));

  // R6: enable count per frame equals the step
  p_frame_count_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> ((enCnt + {{FRAME_BITS{1'b0}}, clkEn}) == (FULL_STEP - {1'b0, activeFrac})));

  // R7: staged value frozen while a request is pending
  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    kickQ |=> $stable(shadowFrac));

endmodule

bind frac_rate_ctrl frac_rate_ctrl_chk #(
  .DATA_W     (DATA_W),
  .FRAME_BITS (FRAME_BITS),
  .KICK_BIT   (KICK_BIT)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .regSel     (regSel),
  .rdData     (rdData),
  .clkEn      (clkEn),
  .kickQ      (kickQ),
  .frameEnd   (frameEnd),
  .activeFrac (activeFrac),
  .shadowFrac (shadowFrac)
);

// File: tb/frac_rate_ctrl_test.sv
module frac_rate_ctrl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regSel = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        clkEn;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // behavioural reference state
  int   posM = 0;
  int   activeM = 0;
  int   shadowM = 0;
  int   otherM = 0;
  bit   kickM = 0;
  string enTag = "R1";

  always #2.5 clk = ~clk;

  frac_rate_ctrl uut (
    .clk    (clk),
    .rstN   (rstN),
    .regSel (regSel),
    .wrEn   (wrEn),
    .wrData (wrData),
    .rdData (rdData),
    .clkEn  (clkEn)
  );

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h (pos %0d)", tag, got, exp, posM);
    end
  endtask

  function automatic bit expEn();
    int s = 32 - activeM;
    return (((posM + 1) * s) / 32) != ((posM * s) / 32);
  endfunction

  function automatic logic [31:0] expRd(input bit sel);
    logic [31:0] v;
    if (sel) begin
      v = '0;
      v[31] = kickM;
    end else begin
      v = otherM;
      v[12:8] = shadowM[4:0];
    end
    return v;
  endfunction

  // one parent cycle: drive, compare, clock, update reference
  task automatic cyc(input bit we, input bit sel, input logic [31:0] d);
    regSel = sel;
    wrEn   = we;
    wrData = d;
    #1;
    check(enTag, clkEn, expEn());
    check(sel ? "R3" : "R2", rdData, expRd(sel));
    @(posedge clk);
    if (we && !sel) begin
      otherM = d & ~32'h0000_1F00;
      if (!kickM) shadowM = d[12:8];
    end
    if (kickM && posM == 31) begin
      activeM = shadowM;
      kickM   = 0;
    end else if (we && sel && d[31]) begin
      kickM = 1;
    end
    posM = (posM + 1) % 32;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 1, '0);
  endtask

  task automatic setFrac(input int f, input logic [31:0] rest);
    cyc(1, 0, (rest & ~32'h0000_1F00) | (32'(f) << 8));
  endtask

  // set the request and poll until it reads 0
  task automatic kickAndWait();
    int n = 0;
    cyc(1, 1, 32'h8000_0000);
    while (n < 40) begin
      #1;
      if (rdData[31] == 1'b0) break;
      cyc(0, 1, '0);
      n++;
    end
    check("R5", (n <= 32), 1);
  endtask

  task automatic runFrac(input int f);
    enTag = "R4";
    setFrac(f, 32'h1234_0056);
    idle(5);
    enTag = "R6";
    kickAndWait();
    idle(64);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values visible at the port
    #1;
    check("R1", clkEn, 1);
    regSel = 1'b1; #0.1;
    check("R1", rdData, 0);
    @(negedge clk);
    rstN = 1'b1;
    enTag = "R1";
    idle(40);

    // R2: other bits preserved with the field
    enTag = "R4";
    cyc(1, 0, 32'hDEAD_BEEF);
    cyc(0, 0, '0);
    idle(10);
    // R3: writing zero to the request bit, other bits set
    cyc(1, 1, 32'h7FFF_FFFF);
    cyc(0, 1, '0);
    enTag = "R6";
    kickAndWait();
    idle(64);

    runFrac(31);
    runFrac(16);
    runFrac(1);
    runFrac(7);
    runFrac(20);

    // R7: field write while pending is ignored, other bits taken
    setFrac(12, 32'h0);
    cyc(1, 1, 32'h8000_0000);
    cyc(1, 0, 32'hA5A5_0300);
    cyc(1, 1, 32'h0000_0000);   // R3: zero does not cancel
    #1;
    check("R3", rdData[31], 1);
    cyc(0, 0, '0);
    #1;
    check("R7", rdData[12:8], 12);
    check("R7", rdData & ~32'h1F00, 32'hA5A5_0000);
    while (kickM) cyc(0, 1, '0);
    idle(64);

    // R8: request written on the completing cycle is dropped
    setFrac(3, 32'h0);
    while (posM != 30) cyc(0, 1, '0);
    cyc(1, 1, 32'h8000_0000);
    cyc(1, 1, 32'h8000_0000);
    #1;
    check("R8", rdData[31], 0);
    idle(3);
    #1;
    check("R8", rdData[31], 0);
    idle(64);

    // back to full rate
    runFrac(0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule